// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows a processor core through its clock-control power states. The states are Normal, AutoHALT, Stop-Grant, a snoop-service state, Sleep, Deep Sleep, and a PLL-settle state that sits between Deep Sleep and Sleep. Four active-low request pins move it along the ladder: stop-clock, halt, sleep and deep-sleep. A snoop strobe and a snoop-done indication decide entry to and exit from the snoop-service state. The block drives a core clock enable, a PLL enable and a snoop-allowed flag. All three are registered and always match the state output.

Sideband events can arrive while the core is granted a clock stop. These are the management interrupt, init, bus-init and local-interrupt lines. The block latches each of them once and hands them back as a one-cycle pulse when the core returns to Normal. The block also watches the request pins for sequences that break the ladder and reports them on a sticky protocol-violation flag. The wait for the PLL to recover after Deep Sleep is a cycle count derived from the clock frequency.

Top module: `lpstate_ctrl`

## Requirements
- R1: With `rst` high at a clock edge, the controller goes to Normal (state 0) and clears all latched events. After that edge: `core_clk_en`=1, `pll_en`=1, `snoop_ok`=0, `evt_pend`=0, `proto_err`=0. Reset takes effect from any state, Sleep and Deep Sleep included.
- R2: The state codes are Normal=0, AutoHALT=1, Stop-Grant=2, Snoop=3, Sleep=4, Deep=5, Settle=6. From Normal, a low `halt_req_n` enters AutoHALT. A high `halt_req_n` in AutoHALT returns to Normal. A low `stop_req_n` in Normal or AutoHALT enters Stop-Grant, and it takes priority over halt.
- R3: In AutoHALT or Stop-Grant, a `snoop_req` strobe enters Snoop, and it takes priority over every other request. The controller stays in Snoop until `snoop_done` is high, then goes back to the state it came from. In Normal, `snoop_req` is ignored.
- R4: Events on `evt_in` are captured in Stop-Grant, and in Snoop when Snoop was entered from Stop-Grant. The bits are: bit 0 management interrupt, bit 1 init, bit 2 bus-init, bit 3 local interrupt. Each bit is reported at most once, however many times it fired. When a high `stop_req_n` in Stop-Grant returns the controller to Normal, `evt_pend` shows the captured bits for exactly one cycle, together with the state change. Events seen in Normal are not captured.
- R5: A low `sleep_req_n` enters Sleep only from Stop-Grant. In Normal, AutoHALT or Snoop, a low `sleep_req_n` sets `proto_err` and causes no state change.
- R6: In Sleep, `core_clk_en`=0, `pll_en`=1 and `snoop_ok`=0. A low `deep_req_n` in Sleep enters Deep Sleep, which is the only state with `pll_en`=0. Deep Sleep can only be entered from Sleep.
- R7: A high `deep_req_n` in Deep Sleep enters Settle, with `pll_en`=1. The controller stays in Settle for exactly SETTLE_US×CLK_MHZ cycles and then enters Sleep. From Sleep, a high `sleep_req_n` returns to Stop-Grant.
- R8: `sleep_req_n` must be sampled low on at least MIN_SLEEP_CYC edges, counting the edge that entered Sleep. Leaving Sleep earlier still returns to Stop-Grant but sets `proto_err`.
- R9: A `snoop_req` or any `evt_in` bit while in Sleep, Deep Sleep or Settle sets `proto_err` and changes no state.
- R10: Reset while in Sleep or Deep Sleep goes straight to Normal without visiting Stop-Grant. Events latched before that reset are never delivered.
- R11: `proto_err` stays high until reset.
- R12: `core_clk_en` is high only in Normal and Snoop. `snoop_ok` is high only in AutoHALT and Stop-Grant.
- R13: Two more cases set `proto_err`: a low `deep_req_n` in any state other than Sleep or Deep Sleep, and a high `sleep_req_n` in Deep Sleep or Settle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_req_n | input | 1 | Stop-clock request, active low |
| halt_req_n | input | 1 | Halt request, active low |
| sleep_req_n | input | 1 | Sleep request, active low |
| deep_req_n | input | 1 | Deep-sleep request, active low |
| snoop_req | input | 1 | Snoop request strobe |
| snoop_done | input | 1 | Snoop serviced |
| evt_in | input | N_EVT | Sideband event inputs |
| state | output | 3 | Current state code |
| core_clk_en | output | 1 | Internal clock enable |
| pll_en | output | 1 | PLL enable |
| snoop_ok | output | 1 | Snoops accepted in this state |
| evt_pend | output | N_EVT | Latched events, one-cycle pulse on return to Normal |
| proto_err | output | 1 | Sticky protocol violation |

## Verification
The hardest situation to reach from the ports is the return from Settle into Sleep. Getting there takes the full legal ladder through Stop-Grant, Sleep and Deep Sleep, then a release of deep-sleep and a wait of the whole settle count. The bench walks that ladder with the sleep pin held for longer than the minimum dwell. It checks that the state is still Settle one cycle before the count ends and is Sleep exactly at the end. It also sweeps all sixteen event patterns through a Stop-Grant round trip, and it tries a sleep request in each state where one is illegal.

// File: rtl/lpstate_pkg.sv
package lpstate_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_AHALT  = 3'd1,
    ST_STOPG  = 3'd2,
    ST_SNOOP  = 3'd3,
    ST_SLEEP  = 3'd4,
    ST_DEEP   = 3'd5,
    ST_SETTLE = 3'd6
  } lp_state_e;
endpackage

// File: rtl/lpstate_settle_timer.sv
module lpstate_settle_timer #(
  parameter int CYC = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int CW = (CYC > 1) ? $clog2(CYC + 1) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start)         cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/lpstate_evt_latch.sv
module lpstate_evt_latch #(
  parameter int N_EVT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic             release_now,
  input  logic [N_EVT-1:0] evt_in,
  output logic [N_EVT-1:0] pend_q
);
  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    logic held_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        held_q    <= 1'b0;
        pend_q[i] <= 1'b0;
      end else if (release_now) begin
        held_q    <= 1'b0;
        pend_q[i] <= held_q | evt_in[i];
      end else begin
        pend_q[i] <= 1'b0;
        if (cap_en && evt_in[i]) held_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lpstate_fsm.sv
module lpstate_fsm
  import lpstate_pkg::*;
#(
  parameter int MIN_SLEEP_CYC = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      stop_n,
  input  logic      halt_n,
  input  logic      sleep_n,
  input  logic      deep_n,
  input  logic      snoop_req,
  input  logic      snoop_done,
  input  logic      evt_any,
  input  logic      settle_done,
  output lp_state_e state_q,
  output logic      clk_en_q,
  output logic      pll_en_q,
  output logic      snoop_ok_q,
  output logic      err_q,
  output logic      cap_en,
  output logic      release_now,
  output logic      settle_start
);
  localparam int CW = $clog2(MIN_SLEEP_CYC + 1);
  localparam logic [CW-1:0] DW_MIN = CW'(MIN_SLEEP_CYC);

  lp_state_e     nxt;
  logic          from_grant_q, from_grant_d;
  logic [CW-1:0] dwell_q, dwell_d;
  logic          viol;

  always_comb begin
    nxt          = state_q;
    from_grant_d = from_grant_q;
    dwell_d      = dwell_q;
    release_now  = 1'b0;
    settle_start = 1'b0;
    case (state_q)
      ST_NORMAL: begin
        if (!stop_n)      nxt = ST_STOPG;
        else if (!halt_n) nxt = ST_AHALT;
      end
      ST_AHALT: begin
        if (snoop_req) begin
          nxt = ST_SNOOP;
          from_grant_d = 1'b0;
        end else if (!stop_n) nxt = ST_STOPG;
        else if (halt_n)      nxt = ST_NORMAL;
      end
      ST_STOPG: begin
        if (snoop_req) begin
          nxt = ST_SNOOP;
          from_grant_d = 1'b1;
        end else if (!sleep_n) begin
          nxt     = ST_SLEEP;
          dwell_d = CW'(1);
        end else if (stop_n) begin
          nxt         = ST_NORMAL;
          release_now = 1'b1;
        end
      end
      ST_SNOOP: begin
        if (snoop_done) nxt = from_grant_q ? ST_STOPG : ST_AHALT;
      end
      ST_SLEEP: begin
        if (!sleep_n && dwell_q < DW_MIN) dwell_d = dwell_q + 1'b1;
        if (!deep_n)     nxt = ST_DEEP;
        else if (sleep_n) nxt = ST_STOPG;
      end
      ST_DEEP: begin
        if (deep_n) begin
          nxt          = ST_SETTLE;
          settle_start = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (settle_done) nxt = ST_SLEEP;
      end
      default: nxt = ST_NORMAL;
    endcase
  end

  always_comb begin
    viol = 1'b0;
    if (!sleep_n && (state_q inside {ST_NORMAL, ST_AHALT, ST_SNOOP})) viol = 1'b1;
    if (!deep_n && !(state_q inside {ST_SLEEP, ST_DEEP}))             viol = 1'b1;
    if ((snoop_req || evt_any) && (state_q inside {ST_SLEEP, ST_DEEP, ST_SETTLE})) viol = 1'b1;
    if (sleep_n && (state_q inside {ST_DEEP, ST_SETTLE}))             viol = 1'b1;
    if (state_q == ST_SLEEP && deep_n && sleep_n && dwell_q < DW_MIN) viol = 1'b1;
  end

  assign cap_en = (state_q == ST_STOPG) || (state_q == ST_SNOOP && from_grant_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_NORMAL;
      from_grant_q <= 1'b0;
      dwell_q      <= '0;
      clk_en_q     <= 1'b1;
      pll_en_q     <= 1'b1;
      snoop_ok_q   <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      state_q      <= nxt;
      from_grant_q <= from_grant_d;
      dwell_q      <= dwell_d;
      clk_en_q     <= (nxt == ST_NORMAL) || (nxt == ST_SNOOP);
      pll_en_q     <= (nxt != ST_DEEP);
      snoop_ok_q   <= (nxt == ST_AHALT) || (nxt == ST_STOPG);
      err_q        <= err_q | viol;
    end
  end
endmodule

// File: rtl/lpstate_ctrl.sv
module lpstate_ctrl
  import lpstate_pkg::*;
#(
  parameter int CLK_MHZ       = 50,
  parameter int SETTLE_US     = 30,
  parameter int MIN_SLEEP_CYC = 2,
  parameter int N_EVT         = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_req_n,
  input  logic             halt_req_n,
  input  logic             sleep_req_n,
  input  logic             deep_req_n,
  input  logic             snoop_req,
  input  logic             snoop_done,
  input  logic [N_EVT-1:0] evt_in,
  output logic [2:0]       state,
  output logic             core_clk_en,
  output logic             pll_en,
  output logic             snoop_ok,
  output logic [N_EVT-1:0] evt_pend,
  output logic             proto_err
);
  localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;

  lp_state_e st;
  logic      cap_en, release_now, settle_start, settle_done;

  lpstate_fsm #(.MIN_SLEEP_CYC(MIN_SLEEP_CYC)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .stop_n      (stop_req_n),
    .halt_n      (halt_req_n),
    .sleep_n     (sleep_req_n),
    .deep_n      (deep_req_n),
    .snoop_req   (snoop_req),
    .snoop_done  (snoop_done),
    .evt_any     (|evt_in),
    .settle_done (settle_done),
    .state_q     (st),
    .clk_en_q    (core_clk_en),
    .pll_en_q    (pll_en),
    .snoop_ok_q  (snoop_ok),
    .err_q       (proto_err),
    .cap_en      (cap_en),
    .release_now (release_now),
    .settle_start(settle_start)
  );

  lpstate_evt_latch #(.N_EVT(N_EVT)) u_evt (
    .clk        (clk),
    .rst        (rst),
    .cap_en     (cap_en),
    .release_now(release_now),
    .evt_in     (evt_in),
    .pend_q     (evt_pend)
  );

  lpstate_settle_timer #(.CYC(SETTLE_CYC)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .start(settle_start),
    .done (settle_done)
  );

  assign state = st;
endmodule

// File: rtl/lpstate_ctrl_chk.sv
module lpstate_ctrl_chk #(
  parameter int N_EVT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       state,
  input logic             pll_en,
  input logic             snoop_done,
  input logic [N_EVT-1:0] evt_pend,
  input logic             proto_err
);
  // R5: Sleep is reached only from Stop-Grant, or it was already Sleep/Settle
  a_r5_sleep_only_from_grant: assert property (@(posedge clk) disable iff (rst)
    state == 3'd4 |-> ($past(state) inside {3'd2, 3'd4, 3'd6}));

  a_r6_deep_only_from_sleep: assert property (@(posedge clk) disable iff (rst)
    state == 3'd5 |-> ($past(state) inside {3'd4, 3'd5}));

  a_r6_pll_off_in_deep: assert property (@(posedge clk) disable iff (rst)
    state == 3'd5 |-> !pll_en);

  a_r7_settle_leads_to_sleep: assert property (@(posedge clk) disable iff (rst)
    state == 3'd6 |=> (state inside {3'd4, 3'd6}));

  a_r7_pll_on_in_settle: assert property (@(posedge clk) disable iff (rst)
    state == 3'd6 |-> pll_en);

  a_r3_snoop_return: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd3 && snoop_done) |=> (state inside {3'd1, 3'd2}));

  a_r4_pend_only_on_release: assert property (@(posedge clk) disable iff (rst)
    (|evt_pend) |-> (state == 3'd0 && $past(state) == 3'd2));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
endmodule

bind lpstate_ctrl lpstate_ctrl_chk #(.N_EVT(N_EVT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .state     (state),
  .pll_en    (pll_en),
  .snoop_done(snoop_done),
  .evt_pend  (evt_pend),
  .proto_err (proto_err)
);

// File: tb/sim_lpstate_ctrl.sv
`timescale 1ns/1ps
module sim_lpstate_ctrl;
  localparam int CLK_MHZ = 50;
  localparam int SETTLE  = 30 * CLK_MHZ;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_n = 1'b1, halt_n = 1'b1, sleep_n = 1'b1, deep_n = 1'b1;
  logic snoop = 1'b0, done = 1'b0;
  logic [3:0] evt = '0;
  logic [2:0] state;
  logic clk_en, pll_en, snoop_ok, err;
  logic [3:0] pend;

  int vecs = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lpstate_ctrl #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(30), .MIN_SLEEP_CYC(2), .N_EVT(4)) u0 (
    .clk(clk), .rst(rst), .stop_req_n(stop_n), .halt_req_n(halt_n),
    .sleep_req_n(sleep_n), .deep_req_n(deep_n), .snoop_req(snoop),
    .snoop_done(done), .evt_in(evt), .state(state), .core_clk_en(clk_en),
    .pll_en(pll_en), .snoop_ok(snoop_ok), .evt_pend(pend), .proto_err(err));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    stop_n = 1; halt_n = 1; sleep_n = 1; deep_n = 1; snoop = 0; done = 0; evt = '0;
  endtask

  task automatic do_reset();
    idle();
    rst = 1; step(); step();
    rst = 0;
  endtask

  task automatic to_grant();
    stop_n = 0; step();
  endtask

  task automatic to_deep();
    to_grant();
    sleep_n = 0; step(); step();
    deep_n = 0; step();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset values
    chk("R1 state", state, 0);
    chk("R1 clk_en", clk_en, 1);
    chk("R1 pll_en", pll_en, 1);
    chk("R1 snoop_ok", snoop_ok, 0);
    chk("R1 pend", pend, 0);
    chk("R1 err", err, 0);

    // R2 halt in and out, R12 enables in AutoHALT
    halt_n = 0; step();
    chk("R2 ahalt", state, 1);
    chk("R12 ahalt clk_en", clk_en, 0);
    chk("R12 ahalt snoop_ok", snoop_ok, 1);
    halt_n = 1; step();
    chk("R2 back normal", state, 0);
    // R2 stop has priority over halt
    stop_n = 0; halt_n = 0; step();
    chk("R2 stop prio", state, 2);
    chk("R12 grant clk_en", clk_en, 0);
    chk("R12 grant snoop_ok", snoop_ok, 1);
    do_reset();
    halt_n = 0; step(); stop_n = 0; step();
    chk("R2 ahalt to grant", state, 2);

    // R3 snoop ignored in Normal, serviced from AutoHALT
    do_reset();
    snoop = 1; step(); snoop = 0;
    chk("R3 normal ignores snoop", state, 0);
    halt_n = 0; step();
    snoop = 1; step(); snoop = 0;
    chk("R3 enter snoop", state, 3);
    chk("R12 snoop clk_en", clk_en, 1);
    step(); step();
    chk("R3 hold snoop", state, 3);
    done = 1; step(); done = 0;
    chk("R3 return ahalt", state, 1);

    // R4 sweep of all event patterns
    for (int p = 0; p < 16; p++) begin
      do_reset();
      evt = 4'(p); step(); evt = '0;
      chk("R4 normal no pend", pend, 0);
      to_grant();
      evt = 4'(p); step(); evt = '0; step();
      evt = 4'(p); step(); evt = '0;
      stop_n = 1; step();
      chk("R4 release state", state, 0);
      chk("R4 pend pattern", pend, p);
      step();
      chk("R4 pend one cycle", pend, 0);
    end
    // R4 events captured during snoop entered from Stop-Grant
    do_reset();
    to_grant();
    snoop = 1; step(); snoop = 0;
    evt = 4'b0101; step(); evt = '0;
    done = 1; step(); done = 0;
    chk("R3 return grant", state, 2);
    stop_n = 1; step();
    chk("R4 snoop-time events", pend, 5);

    // R5 illegal sleep in Normal, AutoHALT, Snoop
    for (int s = 0; s < 3; s++) begin
      do_reset();
      if (s >= 1) begin halt_n = 0; step(); end
      if (s == 2) begin snoop = 1; step(); snoop = 0; end
      sleep_n = 0; step(); sleep_n = 1;
      chk("R5 no state change", state, (s == 0) ? 0 : (s == 1) ? 1 : 3);
      chk("R5 err", err, 1);
    end
    // R11 err sticky until reset
    halt_n = 1; snoop = 0; done = 1; step(); done = 0; step();
    chk("R11 err sticky", err, 1);
    do_reset();
    chk("R11 err cleared by reset", err, 0);

    // R6 R7 legal ladder with full settle
    to_grant();
    sleep_n = 0; step();
    chk("R6 sleep", state, 4);
    chk("R6 sleep clk_en", clk_en, 0);
    chk("R6 sleep pll", pll_en, 1);
    chk("R12 sleep snoop_ok", snoop_ok, 0);
    step();
    deep_n = 0; step();
    chk("R6 deep", state, 5);
    chk("R6 deep pll", pll_en, 0);
    step(); step();
    deep_n = 1; step();
    chk("R7 settle", state, 6);
    chk("R7 settle pll", pll_en, 1);
    repeat (SETTLE - 1) step();
    chk("R7 still settling", state, 6);
    step();
    chk("R7 settle done", state, 4);
    sleep_n = 1; step();
    chk("R7 back to grant", state, 2);
    chk("R13 legal ladder err", err, 0);

    // R8 short and adequate sleep pulses
    do_reset();
    to_grant();
    sleep_n = 0; step(); sleep_n = 1; step();
    chk("R8 short exit state", state, 2);
    chk("R8 short pulse err", err, 1);
    do_reset();
    to_grant();
    sleep_n = 0; step(); step(); sleep_n = 1; step();
    chk("R8 ok exit state", state, 2);
    chk("R8 ok pulse err", err, 0);

    // R9 snoop in Sleep, event in Deep
    do_reset();
    to_grant();
    sleep_n = 0; step(); step();
    snoop = 1; step(); snoop = 0;
    chk("R9 sleep snoop state", state, 4);
    chk("R9 sleep snoop err", err, 1);
    do_reset();
    to_deep();
    evt = 4'b0010; step(); evt = '0;
    chk("R9 deep evt state", state, 5);
    chk("R9 deep evt err", err, 1);

    // R13 deep in Normal, sleep release in Deep
    do_reset();
    deep_n = 0; step(); deep_n = 1;
    chk("R13 deep in normal state", state, 0);
    chk("R13 deep in normal err", err, 1);
    do_reset();
    to_deep();
    sleep_n = 1; step();
    chk("R13 sleep release in deep state", state, 5);
    chk("R13 sleep release in deep err", err, 1);

    // R10 reset from Deep with latched events
    do_reset();
    to_grant();
    evt = 4'hF; step(); evt = '0;
    sleep_n = 0; step(); step();
    deep_n = 0; step();
    chk("R10 in deep", state, 5);
    idle(); rst = 1; step();
    chk("R10 reset to normal", state, 0);
    chk("R10 pll back", pll_en, 1);
    rst = 0;
    to_grant(); stop_n = 1; step();
    chk("R10 latches cleared", pend, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule